// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a 32-bit little-endian data memory port and the register file. It handles byte, halfword and word transfers. On a load it takes the full memory word and the two low address bits. It picks the addressed byte or halfword and returns it right-aligned, filled with zeros or with copies of its top bit. On a store it copies the register operand into every byte lane the access could use and raises a byte-enable only on the lanes that are written.

Each access is checked against its natural alignment. A misaligned access, or an access with the reserved size code, raises an alignment-fault flag and writes no byte lanes. All outputs are registered: an access presented with `accValid` in one cycle appears on the outputs after the next rising clock edge. Address generation, base write-back and multi-register transfers are handled elsewhere.

Top module: `byteLaneAligner`

## Requirements
- R1: A word load (`accSize`=2'b10) at `addrLow`=0 returns the memory word unchanged. Memory is little-endian: the byte at the lowest address sits in bits 7:0.
- R2: An unsigned byte load (`accSize`=2'b00, `accSigned`=0) returns byte lane `addrLow` of the memory word, which is bits 8*addrLow+7 to 8*addrLow, with zeros in bits 31:8.
- R3: An unsigned halfword load (`accSize`=2'b01) returns the low halfword when `addrLow`=0 and the high halfword when `addrLow`=2, with zeros in bits 31:16.
- R4: A signed halfword load (`accSigned`=1) fills bits 31:16 with bit 15 of the selected halfword.
- R5: A signed byte load fills bits 31:8 with bit 7 of the selected byte.
- R6: A byte store makes `byteEn` one-hot with bit `addrLow` set, and drives the low byte of `storeData` on all four lanes of `memWdata`.
- R7: A halfword store sets `byteEn` to 4'b0011 at `addrLow`=0 and to 4'b1100 at `addrLow`=2, and drives the low halfword of `storeData` on both halves of `memWdata`.
- R8: An aligned word store sets `byteEn` to 4'b1111 and passes `storeData` to `memWdata` unchanged.
- R9: A halfword access with `addrLow[0]`=1, a word access with `addrLow`!=0, or any access with `accSize`=2'b11 sets `alignFault`, forces `byteEn` to zero, and returns zero on `loadData`.
- R10: Results appear one clock after the access: `outValid` follows `accValid` with one cycle of delay. `byteEn` is zero for loads and idle cycles, and `alignFault` is zero in idle cycles.
- R11: While reset is held, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | An access is presented this cycle |
| accIsStore | input | 1 | 1 for a store, 0 for a load |
| accSize | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| accSigned | input | 1 | Sign-extend a load result |
| addrLow | input | 2 | Low two bits of the byte address |
| memRdata | input | 32 | Word read from memory |
| storeData | input | 32 | Register operand of a store |
| outValid | output | 1 | Registered result is valid |
| loadData | output | 32 | Aligned and extended load result |
| memWdata | output | 32 | Store data replicated across lanes |
| byteEn | output | 4 | Per-lane write enable, bit i covers bits 8i+7:8i |
| alignFault | output | 1 | Access violated its size alignment |

## Verification
The alignment check and the store lane-enable logic act on the same access in the same cycle. A misaligned store therefore has to raise the fault and also suppress the enable it would otherwise produce. The bench sends halfword and word stores at odd and unaligned offsets between aligned stores. It judges each one on both `alignFault` and `byteEn` in the same sampled cycle. The aligned stores around it must still show their own lanes, which shows that the suppression is not carried over from one access to the next.

// File: rtl/byteLanePkg.sv
package byteLanePkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } accSize_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic [OFF_W-1:0] lane;
    accSize_e         size;
    logic             signExt;
    logic             fault;
    logic             storeEn;
  } laneCtrl_t;
endpackage

// File: rtl/laneCtrl.sv
module laneCtrl
  import byteLanePkg::*;
(
  input  logic             accValid,
  input  logic             accIsStore,
  input  logic [1:0]       accSize,
  input  logic             accSigned,
  input  logic [OFF_W-1:0] addrLow,
  output laneCtrl_t        ctrl,
  output logic [LANES-1:0] laneMask
);
  accSize_e         sizeE;
  logic             misAligned;
  logic [LANES-1:0] rawMask;

  always_comb begin
    sizeE = accSize_e'(accSize);
    unique case (sizeE)
      SZ_BYTE: begin misAligned = 1'b0;       rawMask = LANES'(1) << addrLow; end
      SZ_HALF: begin misAligned = addrLow[0]; rawMask = LANES'(3) << addrLow; end
      SZ_WORD: begin misAligned = |addrLow;   rawMask = {LANES{1'b1}};        end
      default: begin misAligned = 1'b1;       rawMask = '0;                   end
    endcase
    ctrl.lane    = addrLow;
    ctrl.size    = sizeE;
    ctrl.signExt = accSigned & ~accIsStore;
    ctrl.fault   = accValid & misAligned;
    ctrl.storeEn = accValid & accIsStore & ~misAligned;
    laneMask     = rawMask & {LANES{ctrl.storeEn}};
  end
endmodule

// File: rtl/laneDatapath.sv
module laneDatapath
  import byteLanePkg::*;
(
  input  laneCtrl_t         ctrl,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] storeData,
  output logic [DATA_W-1:0] loadNext,
  output logic [DATA_W-1:0] wdataNext
);
  logic [DATA_W-1:0] shifted;
  logic [7:0]        byteVal;
  logic [15:0]       halfVal;

  always_comb begin
    shifted = memRdata >> {ctrl.lane, 3'b000};
    byteVal = shifted[7:0];
    halfVal = shifted[15:0];
    unique case (ctrl.size)
      SZ_BYTE: loadNext = {{(DATA_W-8){ctrl.signExt & byteVal[7]}}, byteVal};
      SZ_HALF: loadNext = {{(DATA_W-16){ctrl.signExt & halfVal[15]}}, halfVal};
      SZ_WORD: loadNext = memRdata;
      default: loadNext = '0;
    endcase
    if (ctrl.fault) loadNext = '0;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_comb begin
      unique case (ctrl.size)
        SZ_BYTE: wdataNext[8*g +: 8] = storeData[7:0];
        SZ_HALF: wdataNext[8*g +: 8] = storeData[8*(g%2) +: 8];
        default: wdataNext[8*g +: 8] = storeData[8*g +: 8];
      endcase
    end
  end
endmodule

// File: rtl/byteLaneAligner.sv
module byteLaneAligner
  import byteLanePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accIsStore,
  input  logic [1:0]        accSize,
  input  logic              accSigned,
  input  logic [OFF_W-1:0]  addrLow,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] storeData,
  output logic              outValid,
  output logic [DATA_W-1:0] loadData,
  output logic [DATA_W-1:0] memWdata,
  output logic [LANES-1:0]  byteEn,
  output logic              alignFault
);
  laneCtrl_t         ctrl;
  logic [LANES-1:0]  laneMask;
  logic [DATA_W-1:0] loadNext;
  logic [DATA_W-1:0] wdataNext;

  laneCtrl uCtrl (
    .accValid  (accValid),
    .accIsStore(accIsStore),
    .accSize   (accSize),
    .accSigned (accSigned),
    .addrLow   (addrLow),
    .ctrl      (ctrl),
    .laneMask  (laneMask)
  );

  laneDatapath uData (
    .ctrl     (ctrl),
    .memRdata (memRdata),
    .storeData(storeData),
    .loadNext (loadNext),
    .wdataNext(wdataNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      loadData   <= '0;
      memWdata   <= '0;
      byteEn     <= '0;
      alignFault <= 1'b0;
    end else begin
      outValid   <= accValid;
      loadData   <= (accValid && !accIsStore) ? loadNext : '0;
      memWdata   <= ctrl.storeEn ? wdataNext : '0;
      byteEn     <= laneMask;
      alignFault <= ctrl.fault;
    end
  end
endmodule

// File: rtl/byteLaneAlignerChecker.sv
module byteLaneAlignerChecker
  import byteLanePkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic              accIsStore,
  input logic [1:0]        accSize,
  input logic              accSigned,
  input logic [OFF_W-1:0]  addrLow,
  input logic              outValid,
  input logic [DATA_W-1:0] loadData,
  input logic [LANES-1:0]  byteEn,
  input logic              alignFault
);
  AST_FAULT_NO_EN: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> byteEn == '0); // R9

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> outValid); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> (!outValid && byteEn == '0 && !alignFault)); // R10

  AST_LOAD_NO_EN: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accIsStore) |=> byteEn == '0); // R10

  AST_BYTE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accIsStore && accSize == 2'b00) |=> $countones(byteEn) == 1); // R6

  AST_HALF_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accIsStore && accSize == 2'b01 && !addrLow[0]) |=> $countones(byteEn) == 2); // R7

  AST_WORD_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accIsStore && accSize == 2'b10 && addrLow == '0) |=> byteEn == '1); // R8

  AST_HALF_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accIsStore && accSigned && accSize == 2'b01 && !addrLow[0])
      |=> loadData[DATA_W-1:16] == {(DATA_W-16){loadData[15]}}); // R4

  AST_RSVD_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accSize == 2'b11) |=> alignFault); // R9
endmodule

bind byteLaneAligner byteLaneAlignerChecker uChk (
  .clk       (clk),
  .rstN      (rstN),
  .accValid  (accValid),
  .accIsStore(accIsStore),
  .accSize   (accSize),
  .accSigned (accSigned),
  .addrLow   (addrLow),
  .outValid  (outValid),
  .loadData  (loadData),
  .byteEn    (byteEn),
  .alignFault(alignFault)
);

// File: tb/byteLaneAligner_test.sv
module byteLaneAligner_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic        accIsStore = 1'b0;
  logic [1:0]  accSize = 2'b00;
  logic        accSigned = 1'b0;
  logic [1:0]  addrLow = 2'b00;
  logic [31:0] memRdata = '0;
  logic [31:0] storeData = '0;
  logic        outValid;
  logic [31:0] loadData;
  logic [31:0] memWdata;
  logic [3:0]  byteEn;
  logic        alignFault;

  int total = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic        isStore;
    logic [31:0] ld;
    logic [31:0] wd;
    logic [3:0]  en;
    logic        flt;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  always #10 clk = ~clk;

  byteLaneAligner uut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accIsStore(accIsStore),
    .accSize(accSize), .accSigned(accSigned), .addrLow(addrLow),
    .memRdata(memRdata), .storeData(storeData), .outValid(outValid),
    .loadData(loadData), .memWdata(memWdata), .byteEn(byteEn),
    .alignFault(alignFault)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic st, input logic [1:0] sz, input logic sg, input logic [1:0] a,
                       input logic [31:0] rd, input logic [31:0] sd,
                       input logic [31:0] ld, input logic [31:0] wd, input logic [3:0] en,
                       input logic flt, input string tag);
    expItem_t it;
    @(posedge clk); #2;
    accValid = 1'b1; accIsStore = st; accSize = sz; accSigned = sg;
    addrLow = a; memRdata = rd; storeData = sd;
    it.isStore = st; it.ld = ld; it.wd = wd; it.en = en; it.flt = flt; it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: sample mid-cycle, one edge after the driver applied the access
  initial begin
    forever begin
      @(posedge clk); #10;
      if (rstN && outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R10 unexpected outValid", 32'h1, 32'h0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(alignFault == it.flt, {it.tag, " fault"}, 32'(alignFault), 32'(it.flt));
          check(byteEn == it.en, {it.tag, " byteEn"}, 32'(byteEn), 32'(it.en));
          if (!it.isStore)
            check(loadData == it.ld, {it.tag, " loadData"}, loadData, it.ld);
          else if (!it.flt)
            check(memWdata == it.wd, {it.tag, " memWdata"}, memWdata, it.wd);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #10;
    check(outValid == 0 && byteEn == 0 && loadData == 0 && alignFault == 0 && memWdata == 0,
          "R11 reset outputs", {byteEn, 27'(loadData), outValid}, 32'h0);
    @(posedge clk); #2; rstN = 1'b1;

    // loads from little-endian word (bytes 56,23,0D,AE at offsets 0..3)
    drive(0, 2'b10, 0, 2'd0, 32'hAE0D2356, 0, 32'hAE0D2356, 0, 4'h0, 0, "R1 word load");
    drive(0, 2'b00, 0, 2'd0, 32'hAE0D2356, 0, 32'h00000056, 0, 4'h0, 0, "R2 ubyte lane0");
    drive(0, 2'b00, 0, 2'd3, 32'hAE0D2356, 0, 32'h000000AE, 0, 4'h0, 0, "R2 ubyte lane3");
    drive(0, 2'b01, 0, 2'd0, 32'hAE0D2356, 0, 32'h00002356, 0, 4'h0, 0, "R3 uhalf low");
    drive(0, 2'b01, 0, 2'd2, 32'hAE0D2356, 0, 32'h0000AE0D, 0, 4'h0, 0, "R3 uhalf high");
    drive(0, 2'b01, 1, 2'd0, 32'hCDEF8204, 0, 32'hFFFF8204, 0, 4'h0, 0, "R4 shalf neg");
    drive(0, 2'b01, 1, 2'd2, 32'h7FFF8204, 0, 32'h00007FFF, 0, 4'h0, 0, "R4 shalf pos");
    drive(0, 2'b00, 1, 2'd0, 32'hCDEF8204, 0, 32'h00000004, 0, 4'h0, 0, "R5 sbyte pos");
    drive(0, 2'b00, 1, 2'd3, 32'hCDEF8204, 0, 32'hFFFFFFCD, 0, 4'h0, 0, "R5 sbyte neg");
    // stores interleaved with misaligned stores
    drive(1, 2'b00, 0, 2'd2, 0, 32'h00002356, 0, 32'h56565656, 4'b0100, 0, "R6 byte store");
    drive(1, 2'b01, 0, 2'd1, 0, 32'h1234ABCD, 0, 0, 4'b0000, 1, "R9 half store odd");
    drive(1, 2'b01, 0, 2'd2, 0, 32'h1234ABCD, 0, 32'hABCDABCD, 4'b1100, 0, "R7 half store high");
    drive(1, 2'b10, 0, 2'd2, 0, 32'hAE0D2356, 0, 0, 4'b0000, 1, "R9 word store unaligned");
    drive(1, 2'b01, 0, 2'd0, 0, 32'h1234ABCD, 0, 32'hABCDABCD, 4'b0011, 0, "R7 half store low");
    drive(1, 2'b10, 0, 2'd0, 0, 32'hAE0D2356, 0, 32'hAE0D2356, 4'b1111, 0, "R8 word store");
    drive(1, 2'b00, 0, 2'd1, 0, 32'h000000F1, 0, 32'hF1F1F1F1, 4'b0010, 0, "R6 byte store lane1");
    drive(0, 2'b10, 0, 2'd3, 32'hAE0D2356, 0, 32'h0, 0, 4'h0, 1, "R9 word load unaligned");
    drive(0, 2'b11, 0, 2'd0, 32'hAE0D2356, 0, 32'h0, 0, 4'h0, 1, "R9 reserved size");

    @(posedge clk); #2; accValid = 1'b0; accIsStore = 1'b1;
    @(posedge clk); @(posedge clk); #10;
    check(outValid == 0 && byteEn == 0 && alignFault == 0, "R10 idle outputs",
          {byteEn, 26'd0, alignFault, outValid}, 32'h0);
    check(expQ.size() == 0, "R10 all results seen", 32'(expQ.size()), 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule